// File: doc/BRIEF.md
# ADC result register bank

This block sits between a four-channel successive-approximation converter and a host bus. A start pulse latches a channel number and a mode. An internal counter then stands in for the conversion time. When the count ends, the 10-bit sample on the data input is captured into one of four read-only result registers. Each register is seen by the bus as an upper byte and a lower byte. Bit 0 of each lower byte is a storage flag that marks unread data. A global end-of-conversion flag tells the host that a result, or a full set of results, is ready.

There are two modes:
- **Single mode:** one conversion runs and its result goes to the register numbered after the channel.
- **Fixed-channel repeat mode:** the one channel is converted again and again. Each result goes to the next register in the order 0, 1, 2, 3, 0 and so on. Repeat mode ends when a single-mode start is issued.

Any bus read clears the end flag. Reading either byte of a register clears that register's storage flag.

Top module: `adc_result_bank`

## Requirements
- R1: After reset, `busy` and `eoc` are 0, and every byte of every result register reads 0x00.
- R2: A result is stored exactly CONV_CYCLES clock edges after the edge that samples `conv_start`, and `busy` stays 1 until then. In single mode `busy` returns to 0 with the store. In repeat mode it stays 1 and a new result is stored every CONV_CYCLES edges.
- R3: In single mode, the result of channel c (`ch_sel` = c) is written to register c.
- R4: In repeat mode, successive results are written to registers 0, 1, 2, 3 and then 0 again. Every `conv_start` returns the write position to register 0.
- R5: `rd_addr[2:1]` selects the register and `rd_addr[0]` selects the byte (1 = upper, 0 = lower). The upper byte holds result bits 9..2. The lower byte holds result bits 1..0 in bits 7..6, zeros in bits 5..1 and the storage flag in bit 0.
- R6: A register's storage flag becomes 1 when a result is written to it. A read of either of its bytes (`rd_en` = 1) clears it.
- R7: When a store and a read of the same register fall on the same edge, the new data is stored and the flag ends up set.
- R8: In single mode, `eoc` becomes 1 with every store. In repeat mode it becomes 1 only with a store into register 3.
- R9: Any read clears `eoc`, unless a store sets it on the same edge.
- R10: A read of one register leaves the storage flags and data of the other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Pulse that begins a conversion and latches mode and channel |
| rep_mode | input | 1 | 1 = fixed-channel repeat, 0 = single conversion |
| ch_sel | input | 2 | Analog channel to convert |
| conv_data | input | 10 | Converter output, captured when the count ends |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 3 | Register number in bits 2..1, byte select in bit 0 |
| rd_data | output | 8 | Selected byte (combinational) |
| busy | output | 1 | A conversion is in progress |
| eoc | output | 1 | End-of-conversion flag |

## Verification
The hardest situation to reach is a bus read that lands on the very edge where a store into the same register happens. The bench counts clock edges from the start pulse and places `rd_en` in the cycle just before the store edge. It then reads the register back to confirm that the flag stayed set.

A second hard case is the end flag during a repeat run. It must stay low over three stores and rise on the fourth. The bench clears it by reading before the run and samples it after each store. A restart in the middle of a run checks that the rotation begins again at register 0.

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int CONV_CYCLES = 132
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_start,
  input  logic       rep_mode,
  input  logic [1:0] ch_sel,
  input  logic [9:0] conv_data,
  input  logic       rd_en,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       eoc
);
  localparam int CNT_W = $clog2(CONV_CYCLES);
  localparam int NREG  = 4;

  logic [CNT_W-1:0] cnt;
  logic [1:0]       ch_q, wptr;
  logic             rep_q;
  logic [7:0]       hi [NREG];
  logic [1:0]       lo [NREG];
  logic [NREG-1:0]  fl;

  wire       store = busy && !conv_start && (cnt == CNT_W'(CONV_CYCLES - 1));
  wire [1:0] widx  = rep_q ? wptr : ch_q;
  wire [1:0] ridx  = rd_addr[2:1];

  assign rd_data = rd_addr[0] ? hi[ridx] : {lo[ridx], 5'b0, fl[ridx]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ch_q  <= '0;
      wptr  <= '0;
      rep_q <= 1'b0;
      busy  <= 1'b0;
    end else if (conv_start) begin
      cnt   <= '0;
      ch_q  <= ch_sel;
      rep_q <= rep_mode;
      wptr  <= '0;
      busy  <= 1'b1;
    end else if (store) begin
      cnt  <= '0;
      busy <= rep_q;
      if (rep_q) wptr <= wptr + 2'd1;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        hi[i] <= '0;
        lo[i] <= '0;
      end
      fl  <= '0;
      eoc <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (store && widx == 2'(i)) begin
          hi[i] <= conv_data[9:2];
          lo[i] <= conv_data[1:0];
          fl[i] <= 1'b1;
        end else if (rd_en && ridx == 2'(i)) begin
          fl[i] <= 1'b0;
        end
      end
      if (store && (!rep_q || wptr == 2'd3)) eoc <= 1'b1;
      else if (rd_en)                        eoc <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [2:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       busy,
  input logic       eoc,
  input logic       store,
  input logic [1:0] widx,
  input logic       rep_q,
  input logic [3:0] fl
);
  a_r6_store_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> fl[$past(widx)]);

  a_r6_read_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(store && widx == rd_addr[2:1])) |=> !fl[$past(rd_addr[2:1])]);

  a_r9_read_clears_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !store) |=> !eoc);

  a_r8_rep_eoc_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (store && rep_q && widx != 2'd3 && !eoc) |=> !eoc);

  a_r5_lower_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_addr[0]) |-> (rd_data[5:1] == 5'd0));

  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !store) |=> busy);

  a_r2_single_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (store && !rep_q) |=> !busy);
endmodule

bind adc_result_bank adc_result_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .busy(busy), .eoc(eoc), .store(store), .widx(widx), .rep_q(rep_q), .fl(fl)
);

// File: tb/adc_result_bank_tb.sv
`timescale 1ns/1ps
module adc_result_bank_tb;
  localparam int N = 132;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_start = 1'b0, rep_mode = 1'b0, rd_en = 1'b0;
  logic [1:0] ch_sel = '0;
  logic [9:0] conv_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, eoc;

  adc_result_bank #(.CONV_CYCLES(N)) u_dut (.*);

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int tgt;
  int m_hi [4], m_lo [4], m_fl [4];
  int m_eoc = 0, m_rep = 0, m_ch = 0, m_ptr = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, input string req);
    int i;
    i = a >> 1;
    rd_en = 1'b1; rd_addr = 3'(a);
    #1;
    chk(req, rd_data, (a & 1) ? m_hi[i] : ((m_lo[i] << 6) | m_fl[i]));
    @(negedge clk);
    rd_en = 1'b0;
    m_fl[i] = 0; m_eoc = 0;
    chk("R9 eoc cleared by read", eoc, 0);
  endtask

  task automatic launch(input int rep, input int ch, input int val);
    conv_start = 1'b1; rep_mode = rep[0]; ch_sel = 2'(ch); conv_data = 10'(val);
    @(negedge clk);
    conv_start = 1'b0;
    tgt = cyc + N;
    m_rep = rep; m_ch = ch; m_ptr = 0;
    chk("R2 busy after start", busy, 1);
  endtask

  task automatic model_store();
    int idx;
    idx = m_rep ? m_ptr : m_ch;
    m_hi[idx] = conv_data >> 2; m_lo[idx] = conv_data & 3; m_fl[idx] = 1;
    if (!m_rep || m_ptr == 3) m_eoc = 1;
    if (m_rep) m_ptr = (m_ptr + 1) % 4;
  endtask

  task automatic wait_store();
    while (cyc < tgt - 1) @(negedge clk);
    chk("R2 busy before store", busy, 1);
    chk("R2 no early eoc change", eoc, m_eoc);
    @(negedge clk);
    model_store();
    tgt = tgt + N;
    chk("R2 busy after store", busy, m_rep);
    chk("R8 eoc after store", eoc, m_eoc);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_hi[i] = 0; m_lo[i] = 0; m_fl[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 busy reset", busy, 0);
    chk("R1 eoc reset", eoc, 0);
    for (int a = 0; a < 8; a++) rd(a, "R1 register reset");

    // R3 R5 R6: single-mode sweep over channels and data patterns
    for (int ch = 0; ch < 4; ch++) begin
      for (int k = 0; k < 4; k++) begin
        int v;
        v = (k == 3) ? ((ch & 1) ? 10'h3FF : 10'h000) : ((ch * 181 + k * 397 + 5) % 1024);
        launch(0, ch, v);
        wait_store();
        if (k[0]) begin
          rd(ch * 2 + 1, "R5 upper byte / R3 routing");
          rd(ch * 2, "R6 upper read cleared flag");
        end else begin
          rd(ch * 2, "R5 lower byte / R6 flag set");
          rd(ch * 2 + 1, "R5 upper byte / R3 routing");
          rd(ch * 2, "R6 lower read cleared flag");
        end
      end
    end

    // R10: read one register, other flags untouched
    for (int ch = 0; ch < 4; ch++) begin
      launch(0, ch, 600 + ch * 7);
      wait_store();
    end
    rd(5, "R10 target upper");
    rd(0, "R10 reg0 flag kept");
    rd(2, "R10 reg1 flag kept");
    rd(4, "R10 reg2 flag cleared");
    rd(6, "R10 reg3 flag kept");

    // R7: read and store of the same register on one edge
    launch(0, 1, 10'h2A5);
    while (cyc < tgt - 1) @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'd2;
    #1;
    chk("R7 old data visible", rd_data, (m_lo[1] << 6) | m_fl[1]);
    @(negedge clk);
    rd_en = 1'b0;
    model_store();
    chk("R7 eoc set wins", eoc, 1);
    rd(2, "R7 flag set after collision");
    rd(3, "R7 new data stored");

    // R4 R8: repeat-mode rotation
    for (int a = 0; a < 8; a++) rd(a, "R6 clear before repeat");
    launch(1, 2, 100);
    for (int n = 0; n < 6; n++) begin
      wait_store();
      chk((n == 3) ? "R8 eoc after reg3" : "R8 eoc state in repeat", eoc, m_eoc);
      conv_data = 10'(100 + (n + 1) * 111);
      if (n == 3) begin
        for (int a = 0; a < 8; a++) rd(a, "R4 rotation contents");
      end
    end
    // R4: restart resets pointer
    launch(1, 0, 333);
    wait_store();
    conv_data = 10'd444;
    wait_store();
    launch(1, 3, 555);
    wait_store();
    rd(0, "R4 restart writes reg0 lower");
    rd(1, "R4 restart writes reg0 upper");
    rd(2, "R4 reg1 unchanged");
    // stop repeat with a single conversion
    launch(0, 3, 777);
    wait_store();
    rd(7, "R3 single after repeat");
    rd(6, "R6 flag cleared");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule